// File: doc/BRIEF.md
# Operand Extend and Byte-Order Unit

This block is a single-stage datapath that reshapes a 32-bit value. It serves two callers. A load path uses it to widen the raw byte or halfword that memory returns, with either zero fill or sign fill. The extend and reverse instructions use it as an execution unit.

A 3-bit operation code picks one of eight shapes:
- zero-extend a byte or a halfword;
- sign-extend a byte or a halfword;
- reverse the order of the four bytes in the word;
- swap the two bytes inside each 16-bit half;
- swap the two bytes of the low half and then sign-extend the result;
- pass the operand through unchanged.

The result is captured in a register on the clock edge that samples a valid input. The result appears one cycle later with a valid flag. The registered result holds its value through cycles that carry no valid input.

Top module: `xr_unit`

## Requirements
- R1: While reset is asserted (rst_ni low), out_valid_o is 0 and result_o is 0.
- R2: Code 0 (3'b000) gives the low byte of the operand with bits 31:8 set to zero, so 0x80 becomes 0x0000_0080.
- R3: Code 1 (3'b001) gives the low byte with bit 7 copied into bits 31:8, so 0x80 becomes 0xFFFF_FF80.
- R4: Code 2 (3'b010) gives the low halfword with bits 31:16 set to zero.
- R5: Code 3 (3'b011) gives the low halfword with bit 15 copied into bits 31:16.
- R6: Code 4 (3'b100) reverses byte order: result byte k equals operand byte 3-k, where byte 0 is bits 7:0.
- R7: Code 5 (3'b101) swaps bytes 0 and 1, and swaps bytes 2 and 3.
- R8: Code 6 (3'b110) places operand byte 0 in bits 15:8 and byte 1 in bits 7:0, then copies bit 15 of that value (operand bit 7) into bits 31:16.
- R9: Code 7 (3'b111) returns the operand unchanged.
- R10: out_valid_o equals in_valid_i of the previous cycle. result_o changes only in the cycle after a valid input, and it holds its value otherwise.
- R11: For codes 0 to 3, operand bits above the byte (codes 0 and 1) or above the halfword (codes 2 and 3) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operand and code are valid this cycle |
| op_i | input | 3 | Operation code (see R2 to R9) |
| operand_i | input | 32 | Input word, or the raw load data in its low bits |
| out_valid_o | output | 1 | result_o carries a new result |
| result_o | output | 32 | Registered result |

## Verification
Every result is due exactly one clock edge after the edge that samples its valid input. The valid flag follows with the same single-cycle delay, and in a cycle without a valid input the result must hold its previous value. The bench drives inputs on falling edges. On the next falling edge it compares both outputs with a behavioural model that stores the outcome of the previous stimulus, so each comparison lands on the cycle in which the result is due. Stimuli include sign-boundary values (0x7F, 0x80, 0x7FFF, 0x8000), extend operands with non-zero upper bits, and random words with gaps between valid inputs.

// File: rtl/xr_pkg.sv
package xr_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = BYTE_W * LANES;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    XR_ZB     = 3'd0,
    XR_SB     = 3'd1,
    XR_ZH     = 3'd2,
    XR_SH     = 3'd3,
    XR_SWAPW  = 3'd4,
    XR_SWAPH  = 3'd5,
    XR_SWAPHS = 3'd6,
    XR_PASS   = 3'd7
  } xr_op_e;
endpackage

// File: rtl/xr_extend.sv
module xr_extend
  import xr_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic              half_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] ext_o
);
  logic fill;

  always_comb begin
    if (half_i) begin
      fill  = signed_i & data_i[HALF_W-1];
      ext_o = {{(DATA_W-HALF_W){fill}}, data_i[HALF_W-1:0]};
    end else begin
      fill  = signed_i & data_i[BYTE_W-1];
      ext_o = {{(DATA_W-BYTE_W){fill}}, data_i[BYTE_W-1:0]};
    end
  end
endmodule

// File: rtl/xr_swap.sv
module xr_swap
  import xr_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] word_o,
  output logic [DATA_W-1:0] halves_o,
  output logic [DATA_W-1:0] half_sx_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_o[g*BYTE_W +: BYTE_W]   = data_i[(LANES-1-g)*BYTE_W +: BYTE_W];
    assign halves_o[g*BYTE_W +: BYTE_W] = data_i[(g^1)*BYTE_W +: BYTE_W];
  end

  assign half_sx_o = {{(DATA_W-HALF_W){halves_o[HALF_W-1]}}, halves_o[HALF_W-1:0]};
endmodule

// File: rtl/xr_out_reg.sv
module xr_out_reg
  import xr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_d, valid_q;
  logic [DATA_W-1:0] data_d, data_q;

  always_comb begin
    valid_d = en_i;
    data_d  = data_q;
    if (en_i) data_d = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/xr_unit.sv
module xr_unit
  import xr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o
);
  xr_op_e            op;
  logic              ext_half, ext_signed;
  logic [DATA_W-1:0] ext_val, swap_word, swap_halves, swap_half_sx;
  logic [DATA_W-1:0] sel_val;

  assign op         = xr_op_e'(op_i);
  assign ext_half   = (op == XR_ZH) || (op == XR_SH);
  assign ext_signed = (op == XR_SB) || (op == XR_SH);

  xr_extend u_ext (
    .data_i   (operand_i),
    .half_i   (ext_half),
    .signed_i (ext_signed),
    .ext_o    (ext_val)
  );

  xr_swap u_swap (
    .data_i    (operand_i),
    .word_o    (swap_word),
    .halves_o  (swap_halves),
    .half_sx_o (swap_half_sx)
  );

  always_comb begin
    unique case (op)
      XR_ZB, XR_SB, XR_ZH, XR_SH: sel_val = ext_val;
      XR_SWAPW:                   sel_val = swap_word;
      XR_SWAPH:                   sel_val = swap_halves;
      XR_SWAPHS:                  sel_val = swap_half_sx;
      default:                    sel_val = operand_i;
    endcase
  end

  xr_out_reg u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (in_valid_i),
    .data_i  (sel_val),
    .valid_o (out_valid_o),
    .data_o  (result_o)
  );
endmodule

// File: rtl/xr_unit_chk.sv
module xr_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [2:0]  op_i,
  input logic [31:0] operand_i,
  input logic        out_valid_o,
  input logic [31:0] result_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (!out_valid_o && result_o == 32'h0);
    end
  end

  a_r10_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r10_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));

  a_r2_zero_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd0) |=> (result_o == {24'h0, $past(operand_i[7:0])}));

  a_r3_sign_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd1) |=>
      (result_o == {{24{$past(operand_i[7])}}, $past(operand_i[7:0])}));

  a_r5_sign_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd3) |=>
      (result_o == {{16{$past(operand_i[15])}}, $past(operand_i[15:0])}));

  a_r6_word_rev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd4) |=>
      (result_o[7:0] == $past(operand_i[31:24]) && result_o[31:24] == $past(operand_i[7:0])));

  a_r8_half_rev_sx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd6) |=>
      (result_o[15:8] == $past(operand_i[7:0]) && result_o[31:16] == {16{$past(operand_i[7])}}));

  a_r9_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd7) |=> (result_o == $past(operand_i)));
endmodule

bind xr_unit xr_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .op_i        (op_i),
  .operand_i   (operand_i),
  .out_valid_o (out_valid_o),
  .result_o    (result_o)
);

// File: tb/xr_unit_tb.sv
`timescale 1ns/1ps
module xr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [31:0] operand;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  logic        exp_valid;
  logic [31:0] exp_result;
  string       exp_tag;
  bit          done = 0;

  always #4 clk = ~clk;

  xr_unit u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .op_i        (op),
    .operand_i   (operand),
    .out_valid_o (out_valid),
    .result_o    (result)
  );

  function automatic logic [31:0] model(int code, logic [31:0] d);
    logic [7:0] b0, b1, b2, b3;
    b0 = d[7:0]; b1 = d[15:8]; b2 = d[23:16]; b3 = d[31:24];
    case (code)
      0: return {24'h0, b0};
      1: return {{24{b0[7]}}, b0};
      2: return {16'h0, b1, b0};
      3: return {{16{b1[7]}}, b1, b0};
      4: return {b0, b1, b2, b3};
      5: return {b2, b3, b0, b1};
      6: return {{16{b0[7]}}, b0, b1};
      default: return d;
    endcase
  endfunction

  function automatic string tag_of(int code, logic [31:0] d);
    if (code == 0 && d[31:8] != 0) return "R11";
    if (code == 1 && d[31:8] != 0) return "R11";
    if (code == 2 && d[31:16] != 0) return "R11";
    if (code == 3 && d[31:16] != 0) return "R11";
    case (code)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_now();
    checks++;
    if (out_valid !== exp_valid) begin
      failures++;
      $display("FAIL R10 out_valid act=%0b exp=%0b", out_valid, exp_valid);
    end
    checks++;
    if (result !== exp_result) begin
      failures++;
      $display("FAIL %s result act=%08h exp=%08h", exp_valid ? exp_tag : "R10",
               result, exp_result);
    end
  endtask

  task automatic step(bit v, int code, logic [31:0] d);
    @(negedge clk);
    check_now();
    in_valid = v;
    op       = code[2:0];
    operand  = d;
    exp_valid = v;
    if (v) begin
      exp_result = model(code, d);
      exp_tag    = tag_of(code, d);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = 3'd0; operand = 32'hDEAD_BEEF;
    exp_valid = 1'b0; exp_result = 32'h0; exp_tag = "R1";
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== 32'h0) begin
        failures++;
        $display("FAIL R1 reset act=%0b/%08h exp=0/00000000", out_valid, result);
      end
    end
    rst_n = 1'b1;
    // boundary values for every code
    for (int c = 0; c < 8; c++) begin
      step(1, c, 32'h0000_0080);
      step(1, c, 32'h0000_007F);
      step(1, c, 32'h0000_8000);
      step(1, c, 32'h0000_7FFF);
      step(1, c, 32'h1234_5678);
      step(1, c, 32'hFFFF_FF01);   // upper garbage for extends (R11)
      step(0, c, 32'hAAAA_5555);   // idle: hold (R10)
      step(1, c, 32'h8765_43F0);
    end
    // back-to-back and gapped random traffic
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, int'($urandom % 8), $urandom);
    end
    step(0, 0, 32'h0);
    step(0, 0, 32'h0);
    @(negedge clk);
    check_now();
    finish_run();
  end
endmodule